// File: doc/BRIEF.md
# SPI Register and FIFO Access Port

This block is an SPI slave front end. An external SPI master uses it to reach a small register file and a set of byte FIFOs that belong to the surrounding core. Each transaction starts when chip select goes low. The first byte is a command byte, which selects an address and a direction. Every later byte of the same transaction either writes the selected location or reads it back on MISO.

Some addresses are plain registers and others are FIFO windows, as marked in a parameter map. A plain register takes only the first data byte of a write, and on a read it returns the same value for every byte. A FIFO window turns each completed byte into one push or one pop, so a whole packet can move in one chip-select period.

The SPI pins are oversampled by the system clock through synchronizers. SCLK may idle low or high: the block works in clock mode (0,0) and in mode (1,1), and in both it samples on the rising edge and shifts out on the falling edge. SCLK must run at no more than a quarter of the system clock. Read data appears on MISO a few system clocks after each falling edge, so the master's sampling point needs that much margin.

Top module: `spi_regport`

## Requirements
- R1: Transfers work with SCLK idling low and with SCLK idling high. MOSI is captured on rising SCLK edges and MISO changes after falling edges. Bits travel most significant first.
- R2: In the command byte, bits [7:3] are the address and bit 1 is the direction (1 = write, 0 = read). Bits 2 and 0 have no effect.
- R3: A write to a plain address gives exactly one reg_we_o pulse, carrying the first data byte on reg_wdata_o and the address on reg_addr_o. Any later bytes of that transaction produce no strobe.
- R4: A write to a FIFO address gives one fifo_push_o pulse for each completed data byte, with that byte on reg_wdata_o.
- R5: A read of a plain address returns reg_rdata_i on MISO for the first data byte, starting right after the command byte, and returns the same value for every further byte. It never pops.
- R6: A read of a FIFO address gives one fifo_pop_o pulse for each completed data byte. The next byte carries the new head from reg_rdata_i.
- R7: Raising chip select ends the transaction. A partly received byte causes no strobe, and the next transaction starts again with a command byte.
- R8: MISO stays low while chip select is high and during the command byte.
- R9: reg_we_o, fifo_push_o and fifo_pop_o are single-cycle pulses, at most one of them is high at a time, and reg_addr_o stays constant during a data phase.
- R10: Bit n of the parameter FIFO_MAP marks address n as a FIFO window. By default addresses 0 to 3 are FIFO windows and every other address is a plain register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock from master |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from master |
| miso_o | output | 1 | SPI data to master |
| reg_addr_o | output | 5 | Address latched from command byte |
| reg_wdata_o | output | 8 | Write data for register or FIFO |
| reg_we_o | output | 1 | Plain register write strobe |
| reg_rdata_i | input | 8 | Read data at reg_addr_o (FIFO head for FIFO addresses) |
| fifo_push_o | output | 1 | FIFO push strobe |
| fifo_pop_o | output | 1 | FIFO pop strobe |

## Verification
The bound checker watches several properties on every cycle. It checks that the three strobes are one-cycle pulses and never overlap, that pushes and pops only occur at FIFO addresses while writes only occur at plain ones, that the address stays constant within a read, and that MISO and all strobes stay quiet once chip select is high. Other behaviour can only be shown by the bench scenarios, which run whole transactions against the reference model. These cover the bit order in both clock modes, the decoding of the command byte with the reserved bits ignored, the repeat on plain-register reads, the one-write-only rule, the pop-then-next-head sequence, and aborts in the command byte or partway through a data byte.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned CNT_W    = $clog2(BYTE_W);
  localparam int unsigned CMD_WR_B = 1;
  localparam int unsigned NUM_ADDR = 1 << ADDR_W;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int unsigned          WIDTH   = 1,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regport_shift.sv
module spi_regport_shift
  import spi_regport_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              tx_en_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              miso_o
);
  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-2:0] rx_q;
  logic [BYTE_W-1:0] tx_q;
  logic              miso_q;
  logic              rise, fall;

  assign rise = cs_act_i &  sclk_i & ~sclk_q;
  assign fall = cs_act_i & ~sclk_i &  sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (!cs_act_i) begin
        bit_cnt_q <= '0;
        rx_q      <= '0;
        tx_q      <= '0;
        miso_q    <= 1'b0;
      end else begin
        if (rise) begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          rx_q      <= {rx_q[BYTE_W-3:0], mosi_i};
        end
        if (fall) begin
          if (!tx_en_i) begin
            miso_q <= 1'b0;
          end else if (bit_cnt_q == '0) begin
            // byte boundary: fetch fresh read data
            miso_q <= tx_data_i[BYTE_W-1];
            tx_q   <= {tx_data_i[BYTE_W-2:0], 1'b0};
          end else begin
            miso_q <= tx_q[BYTE_W-1];
            tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign byte_done_o = rise && (bit_cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o      = {rx_q, mosi_i};
  assign miso_o      = miso_q;
endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
  import spi_regport_pkg::*;
#(
  parameter logic [NUM_ADDR-1:0] FIFO_MAP = 32'h0000_000F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              reg_we_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              tx_en_o
);
  phase_e            phase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              wr_q, wrote_q;
  logic              we_q, push_q, pop_q;
  logic              fifo_hit;

  assign fifo_hit = FIFO_MAP[addr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      wrote_q <= 1'b0;
      we_q    <= 1'b0;
      push_q  <= 1'b0;
      pop_q   <= 1'b0;
    end else begin
      we_q   <= 1'b0;
      push_q <= 1'b0;
      pop_q  <= 1'b0;
      if (!cs_act_i) begin
        phase_q <= PH_CMD;
      end else if (byte_done_i) begin
        if (phase_q == PH_CMD) begin
          addr_q  <= byte_i[BYTE_W-1 -: ADDR_W];
          wr_q    <= byte_i[CMD_WR_B];
          wrote_q <= 1'b0;
          phase_q <= PH_DATA;
        end else if (wr_q) begin
          if (fifo_hit) begin
            push_q  <= 1'b1;
            wdata_q <= byte_i;
          end else if (!wrote_q) begin
            // plain register takes only the first byte
            we_q    <= 1'b1;
            wdata_q <= byte_i;
            wrote_q <= 1'b1;
          end
        end else if (fifo_hit) begin
          pop_q <= 1'b1;
        end
      end
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign reg_we_o = we_q;
  assign push_o   = push_q;
  assign pop_o    = pop_q;
  assign tx_en_o  = (phase_q == PH_DATA) && !wr_q;
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int unsigned         SYNC_STAGES = 2,
  parameter logic [NUM_ADDR-1:0] FIFO_MAP    = 32'h0000_000F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              fifo_push_o,
  output logic              fifo_pop_o
);
  logic [2:0]        pins_s;
  logic              cs_act, sclk_s, mosi_s;
  logic              byte_done, tx_en;
  logic [BYTE_W-1:0] rx_byte;

  spi_regport_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({csn_i, sclk_i, mosi_i}),
    .q_o   (pins_s)
  );

  assign cs_act = ~pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_regport_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sclk_i     (sclk_s),
    .mosi_i     (mosi_s),
    .tx_en_i    (tx_en),
    .tx_data_i  (reg_rdata_i),
    .byte_done_o(byte_done),
    .byte_o     (rx_byte),
    .miso_o     (miso_o)
  );

  spi_regport_ctrl #(
    .FIFO_MAP(FIFO_MAP)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .byte_done_i(byte_done),
    .byte_i     (rx_byte),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .push_o     (fifo_push_o),
    .pop_o      (fifo_pop_o),
    .tx_en_o    (tx_en)
  );
endmodule

// File: rtl/spi_regport_chk.sv
module spi_regport_chk
  import spi_regport_pkg::*;
#(
  parameter logic [NUM_ADDR-1:0] FIFO_MAP = 32'h0000_000F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input logic              tx_en_i,
  input logic              miso_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              push_i,
  input logic              pop_i
);
  a_r9_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({we_i, push_i, pop_i}));

  a_r9_strobe_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i || push_i || pop_i) |=> !(we_i || push_i || pop_i));

  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i)) |-> $stable(addr_i));

  a_r3_we_plain_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !FIFO_MAP[addr_i]);

  a_r4_push_fifo_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> FIFO_MAP[addr_i]);

  a_r6_pop_fifo_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (FIFO_MAP[addr_i] && tx_en_i));

  a_r8_miso_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !miso_i);

  a_r7_idle_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |=> !(we_i || push_i || pop_i));
endmodule

bind spi_regport spi_regport_chk #(.FIFO_MAP(FIFO_MAP)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_act_i(cs_act),
  .tx_en_i (tx_en),
  .miso_i  (miso_o),
  .addr_i  (reg_addr_o),
  .we_i    (reg_we_o),
  .push_i  (fifo_push_o),
  .pop_i   (fifo_pop_o)
);

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
  localparam int          HALF = 6;
  localparam logic [31:0] MAP  = 32'h0000_000F;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic       miso, we, push, pop;
  logic [4:0] addr;
  logic [7:0] wdata, rdata;

  always #4 clk = ~clk;

  spi_regport #(.FIFO_MAP(MAP)) u_spi_regport (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .reg_addr_o(addr), .reg_wdata_o(wdata), .reg_we_o(we),
    .reg_rdata_i(rdata), .fifo_push_o(push), .fifo_pop_o(pop)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // core-side environment: register file and FIFOs driven by strobes
  logic [7:0] core_reg [32];
  logic [7:0] core_mem [32][64];
  int         core_wp  [32];
  int         core_rp  [32];

  initial begin
    for (int i = 0; i < 32; i++) begin
      core_reg[i] = 8'h00; core_wp[i] = 0; core_rp[i] = 0;
    end
  end

  always @(posedge clk) begin
    if (we)   core_reg[addr] <= wdata;
    if (push) begin
      core_mem[addr][core_wp[addr] % 64] <= wdata;
      core_wp[addr] <= core_wp[addr] + 1;
    end
    if (pop)  core_rp[addr] <= core_rp[addr] + 1;
  end

  always_comb begin
    if (MAP[addr])
      rdata = (core_rp[addr] < core_wp[addr]) ? core_mem[addr][core_rp[addr] % 64] : 8'h00;
    else
      rdata = core_reg[addr];
  end

  // expected model
  logic [7:0] exp_reg [32];
  logic [7:0] exp_mem [32][64];
  int         exp_wp  [32];
  int         exp_rp  [32];
  int         ev_q[$];
  string      ev_req[$];

  initial begin
    for (int i = 0; i < 32; i++) begin
      exp_reg[i] = 8'h00; exp_wp[i] = 0; exp_rp[i] = 0;
    end
  end

  // kind: 0 reg write, 1 push, 2 pop
  function automatic int ev_code(input int kind, input int a, input int d);
    return (kind << 16) | (a << 8) | d;
  endfunction

  task automatic expect_ev(input int kind, input int a, input int d, input string req);
    ev_q.push_back(ev_code(kind, a, d));
    ev_req.push_back(req);
  endtask

  // strobe monitor, compared on every clock
  always @(negedge clk) begin
    int    kind;
    int    got;
    int    want;
    string req;
    if (rst_n && (we || push || pop)) begin
      kind = we ? 0 : (push ? 1 : 2);
      got  = ev_code(kind, int'(addr), pop ? 0 : int'(wdata));
      if (ev_q.size() == 0) begin
        chk(1'b0, "R9 unexpected strobe", got, 0);
      end else begin
        want = ev_q.pop_front();
        req  = ev_req.pop_front();
        chk(got == want, req, got, want);
      end
    end
  end

  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  function automatic logic [7:0] mk_cmd(input int a, input bit wr, input bit rsv);
    return {a[4:0], rsv, wr, rsv};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0 or 3; nbits total including the command byte
  task automatic xfer(input int mode, input logic [7:0] cmd, input int nbits);
    logic [7:0] cur;
    logic       cmd_miso;
    cmd_miso = 1'b0;
    @(negedge clk);
    sclk = (mode == 3);
    idle(4);
    csn = 1'b0;
    idle(4);
    for (int k = 0; k * 8 < nbits; k++) begin
      cur = (k == 0) ? cmd : tx_buf[k-1];
      for (int b = 7; b >= 0; b--) begin
        if (k * 8 + (7 - b) < nbits) begin
          if (mode == 3) sclk = 1'b0;
          mosi = cur[b];
          idle(HALF);
          if (k == 0) cmd_miso = cmd_miso | miso;
          else        rx_buf[k-1][b] = miso;
          sclk = 1'b1;
          idle(HALF);
          if (mode == 0) sclk = 1'b0;
        end
      end
    end
    idle(HALF);
    csn = 1'b1;
    idle(8);
    chk(cmd_miso == 1'b0, "R8 miso during command", cmd_miso, 0);
    chk(ev_q.size() == 0, "R7/R9 missing strobes", ev_q.size(), 0);
    ev_q.delete();
    ev_req.delete();
  endtask

  task automatic wr_plain(input int mode, input int a, input int n, input bit rsv, input string req);
    expect_ev(0, a, tx_buf[0], req);
    exp_reg[a] = tx_buf[0];
    xfer(mode, mk_cmd(a, 1'b1, rsv), 8 * (n + 1));
  endtask

  task automatic rd_plain(input int mode, input int a, input int n, input bit rsv, input string req);
    xfer(mode, mk_cmd(a, 1'b0, rsv), 8 * (n + 1));
    for (int i = 0; i < n; i++)
      chk(rx_buf[i] == exp_reg[a], req, rx_buf[i], exp_reg[a]);
  endtask

  task automatic wr_fifo(input int mode, input int a, input int n, input int extra, input string req);
    for (int i = 0; i < n; i++) begin
      expect_ev(1, a, tx_buf[i], req);
      exp_mem[a][exp_wp[a] % 64] = tx_buf[i];
      exp_wp[a]++;
    end
    xfer(mode, mk_cmd(a, 1'b1, 1'b0), 8 * (n + 1) + extra);
  endtask

  task automatic rd_fifo(input int mode, input int a, input int n, input string req);
    logic [7:0] e [16];
    for (int i = 0; i < n; i++) begin
      expect_ev(2, a, 0, req);
      e[i] = exp_mem[a][exp_rp[a] % 64];
      exp_rp[a]++;
    end
    xfer(mode, mk_cmd(a, 1'b0, 1'b0), 8 * (n + 1));
    for (int i = 0; i < n; i++)
      chk(rx_buf[i] == e[i], req, rx_buf[i], e[i]);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    // reset state
    chk(miso == 1'b0, "R8 reset miso", miso, 0);
    chk({we, push, pop} == 3'b000, "R9 reset strobes", {we, push, pop}, 0);
    chk(addr == 5'd0, "R9 reset addr", addr, 0);

    // R1 R3: plain write in mode 0, read back in mode 3
    tx_buf[0] = 8'hA5;
    wr_plain(0, 8, 1, 1'b0, "R3 plain write mode0");
    rd_plain(3, 8, 3, 1'b0, "R5 plain repeat read mode3");
    rd_plain(0, 8, 2, 1'b0, "R1 plain read mode0");

    // R3: extra bytes ignored
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    wr_plain(3, 9, 3, 1'b0, "R3 only first byte written");
    rd_plain(3, 9, 1, 1'b0, "R3 readback first byte");

    // R2: reserved command bits set
    tx_buf[0] = 8'h3C;
    wr_plain(0, 10, 1, 1'b1, "R2 write with reserved bits");
    rd_plain(3, 10, 2, 1'b1, "R2 read with reserved bits");

    // R4 R6: FIFO burst write then two burst reads
    tx_buf[0] = 8'h01; tx_buf[1] = 8'h80; tx_buf[2] = 8'h5A;
    tx_buf[3] = 8'hC3; tx_buf[4] = 8'hFF;
    wr_fifo(3, 2, 5, 0, "R4 fifo push burst");
    rd_fifo(0, 2, 3, "R6 fifo pop burst mode0");
    rd_fifo(3, 2, 2, "R6 fifo pop burst mode3");

    // R10: map boundary, address 3 is FIFO, address 4 plain
    tx_buf[0] = 8'h96; tx_buf[1] = 8'h69;
    wr_fifo(0, 3, 2, 0, "R10 addr3 is fifo");
    wr_plain(0, 4, 2, 1'b0, "R10 addr4 is plain");
    rd_plain(3, 4, 1, 1'b0, "R10 addr4 readback");
    rd_fifo(3, 3, 2, "R10 addr3 fifo read");

    // R7: aborts
    tx_buf[0] = 8'hEE;
    xfer(0, mk_cmd(12, 1'b1, 1'b0), 8 + 5);
    rd_plain(0, 12, 1, 1'b0, "R7 aborted write left reg");
    xfer(3, mk_cmd(13, 1'b1, 1'b0), 3);
    tx_buf[0] = 8'h7E;
    wr_plain(3, 13, 1, 1'b0, "R7 write after command abort");
    rd_plain(0, 13, 1, 1'b0, "R7 readback after abort");
    tx_buf[0] = 8'h24; tx_buf[1] = 8'h42; tx_buf[2] = 8'hDB;
    wr_fifo(0, 1, 2, 3, "R7 partial fifo byte dropped");
    rd_fifo(0, 1, 2, "R7 fifo holds complete bytes");

    summary();
    $finish;
  end
endmodule